// File: doc/BRIEF.md
# Dual-Step 16-Bit Xoroshiro Pseudo-Random Generator

This block produces 32-bit pseudo-random words from a 32-bit generator state. The state is held as two 16-bit halves and advanced by a xoroshiro-style engine. Each engine step yields one 16-bit value through a "plus-plus" scrambler, which uses two modular additions and a rotate.

Each request runs the engine twice within one cycle. The two 16-bit results are packed into one 32-bit word: the earlier result goes in the low half and the later result goes in the high half. The word is returned with a one-cycle valid pulse.

The engine parameters are fixed at 13, 5, 10 and 9. With these, the 16-bit output stream repeats every 2^32-1 steps, and the all-zero state is never reached. Software may load any seed. A zero seed is replaced by a fixed nonzero value so that the generator cannot lock up.

Top module: `prng_pair_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) has the following effects:
  - `randValid` goes to 0 and `randWord` goes to 0.
  - The state is set to the default seed 32'h0000_0001.
  - The first request after reset therefore returns the output of that seed.
- R2: The state layout is fixed as follows:
  - The low half s0 is state bits [15:0].
  - The high half s1 is state bits [31:16].
  - A loaded seed maps straight onto this layout.
- R3: One engine step produces the output rotl16((s0 + s1) mod 2^16, 9) + s0, with the final addition also taken mod 2^16. The output is computed from the state before that step.
- R4: One engine step updates the state as follows, with t = s1 ^ s0:
  - The new s0 is rotl16(s0, 13) ^ t ^ ((t << 5) mod 2^16).
  - The new s1 is rotl16(t, 10).
- R5: A request runs two steps. The first step's output goes to `randWord[15:0]` and the second step's output goes to `randWord[31:16]`. The state then holds the value after both steps.
- R6: `randValid` is high in the cycle after each accepted request (`reqStrobe` high with `seedLoad` low). Back-to-back requests return one new word per cycle.
- R7: In a cycle with no accepted request:
  - `randValid` is 0 in the following cycle.
  - `randWord` holds its value.
  - The state is unchanged.
- R8: When `seedLoad` is high, `seedValue` replaces the state. A load takes priority over a request in the same cycle: that request is dropped, `randValid` stays 0 and `randWord` holds.
- R9: Loading an all-zero seed loads the constant 32'hB5AD_4ECE instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load `seedValue` into the state |
| seedValue | input | 32 | Seed; bits [15:0] go to s0 and bits [31:16] go to s1 |
| reqStrobe | input | 1 | Request one packed word |
| randWord | output | 32 | Packed result: earlier output in the low half, later output in the high half |
| randValid | output | 1 | High for one cycle after each accepted request |

## Verification
The bench sweeps the following seeds, each followed by several requests, against an arithmetic model of the step equations:
- A few dozen scattered seeds.
- Seeds with one half all zero.
- Seeds with every bit set.

A swapped half, a wrong shift or rotate amount, or a carry missing from either addition shows up as a mismatched word.

A long run of back-to-back requests separates a design that advances once per cycle from one that stalls or repeats a word. The following runs check that the state does not drift between requests:
- Idle gaps.
- Loads that collide with requests.
- An all-zero seed.

// File: rtl/prng_pkg.sv
package prng_pkg;

  localparam int unsigned HALF_W   = 16;
  localparam int unsigned STATE_W  = 2 * HALF_W;
  localparam int unsigned STEPS    = 2;
  localparam int unsigned WORD_W   = STEPS * HALF_W;

  localparam int unsigned ROT_A    = 13;
  localparam int unsigned SHIFT_B  = 5;
  localparam int unsigned ROT_C    = 10;
  localparam int unsigned ROT_OUT  = 9;

  localparam logic [STATE_W-1:0] DEFAULT_SEED = 32'h0000_0001;
  localparam logic [STATE_W-1:0] ZERO_SUB     = 32'hB5AD_4ECE;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } ctrlStrobes_t;

endpackage

// File: rtl/prng_step.sv
module prng_step #(
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned ROT_A   = 13,
  parameter int unsigned SHIFT_B = 5,
  parameter int unsigned ROT_C   = 10,
  parameter int unsigned ROT_OUT = 9
) (
  input  logic [2*HALF_W-1:0] stateIn,
  output logic [2*HALF_W-1:0] stateOut,
  output logic [HALF_W-1:0]   outWord
);

  function automatic logic [HALF_W-1:0] rotl(input logic [HALF_W-1:0] v,
                                             input int unsigned n);
    return (v << n) | (v >> (HALF_W - n));
  endfunction

  logic [HALF_W-1:0] lowHalf;
  logic [HALF_W-1:0] highHalf;
  logic [HALF_W-1:0] mixT;
  logic [HALF_W-1:0] sumHalves;
  logic [HALF_W-1:0] newLow;
  logic [HALF_W-1:0] newHigh;

  assign lowHalf  = stateIn[HALF_W-1:0];
  assign highHalf = stateIn[2*HALF_W-1:HALF_W];

  // scrambler: output is taken from the state before the update
  always_comb begin
    sumHalves = lowHalf + highHalf;
    outWord   = rotl(sumHalves, ROT_OUT) + lowHalf;
  end

  // engine update
  always_comb begin
    mixT    = highHalf ^ lowHalf;
    newLow  = rotl(lowHalf, ROT_A) ^ mixT ^ (mixT << SHIFT_B);
    newHigh = rotl(mixT, ROT_C);
  end

  assign stateOut = {newHigh, newLow};

endmodule

// File: rtl/prng_ctrl.sv
module prng_ctrl
  import prng_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         seedLoad,
  input  logic         reqStrobe,
  output ctrlStrobes_t strobes,
  output logic         randValid
);

  logic validQ;

  // a load always wins over a request arriving in the same cycle
  always_comb begin
    strobes.loadSeed = seedLoad;
    strobes.advance  = reqStrobe & ~seedLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= strobes.advance;
  end

  assign randValid = validQ;

endmodule

// File: rtl/prng_datapath.sv
module prng_datapath
  import prng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strobes,
  input  logic [STATE_W-1:0]   seedValue,
  output logic [WORD_W-1:0]    randWord
);

  logic [STATE_W-1:0] stateQ;
  logic [WORD_W-1:0]  resultQ;
  logic [STATE_W-1:0] stageState [0:STEPS];
  logic [WORD_W-1:0]  resultNext;
  logic [STATE_W-1:0] seedSafe;

  assign stageState[0] = stateQ;

  // chain of engine steps, all resolved within one cycle
  for (genvar k = 0; k < STEPS; k++) begin : g_step
    prng_step #(
      .HALF_W (HALF_W),
      .ROT_A  (ROT_A),
      .SHIFT_B(SHIFT_B),
      .ROT_C  (ROT_C),
      .ROT_OUT(ROT_OUT)
    ) u_step (
      .stateIn (stageState[k]),
      .stateOut(stageState[k+1]),
      .outWord (resultNext[k*HALF_W +: HALF_W])
    );
  end

  // an all-zero seed would freeze the engine
  assign seedSafe = (seedValue == '0) ? ZERO_SUB : seedValue;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= DEFAULT_SEED;
      resultQ <= '0;
    end else if (strobes.loadSeed) begin
      stateQ  <= seedSafe;
    end else if (strobes.advance) begin
      stateQ  <= stageState[STEPS];
      resultQ <= resultNext;
    end
  end

  assign randWord = resultQ;

endmodule

// File: rtl/prng_pair_gen.sv
module prng_pair_gen
  import prng_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seedLoad,
  input  logic [31:0] seedValue,
  input  logic        reqStrobe,
  output logic [31:0] randWord,
  output logic        randValid
);

  ctrlStrobes_t strobes;

  prng_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .reqStrobe(reqStrobe),
    .strobes  (strobes),
    .randValid(randValid)
  );

  prng_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .seedValue(seedValue),
    .randWord (randWord)
  );

endmodule

// File: rtl/prng_pair_chk.sv
module prng_pair_chk (
  input logic        clk,
  input logic        rst,
  input logic        seedLoad,
  input logic        reqStrobe,
  input logic [31:0] randWord,
  input logic        randValid
);

  // R6
  valid_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (reqStrobe && !seedLoad) |=> randValid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !reqStrobe |=> !randValid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reqStrobe |=> $stable(randWord));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> (!randValid && $stable(randWord)));

endmodule

bind prng_pair_gen prng_pair_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .seedLoad (seedLoad),
  .reqStrobe(reqStrobe),
  .randWord (randWord),
  .randValid(randValid)
);

// File: tb/tb_prng_pair_gen.sv
module tb_prng_pair_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        seedLoad;
  logic [31:0] seedValue;
  logic        reqStrobe;
  logic [31:0] randWord;
  logic        randValid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model;

  always #10 clk = ~clk;

  prng_pair_gen dut (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
    .reqStrobe(reqStrobe), .randWord(randWord), .randValid(randValid)
  );

  function automatic logic [15:0] rl(input logic [15:0] v, input int n);
    return (v << n) | (v >> (16 - n));
  endfunction

  // R3
  function automatic logic [15:0] outOf(input logic [31:0] st);
    logic [15:0] a, b, s;
    a = st[15:0]; b = st[31:16];
    s = a + b;
    return rl(s, 9) + a;
  endfunction

  // R4
  function automatic logic [31:0] nxt(input logic [31:0] st);
    logic [15:0] a, b, t, na, nb;
    a = st[15:0]; b = st[31:16];
    t = a ^ b;
    na = rl(a, 13) ^ t ^ (t << 5);
    nb = rl(t, 10);
    return {nb, na};
  endfunction

  // R5
  function automatic logic [31:0] pairOf(input logic [31:0] st);
    return {outOf(nxt(st)), outOf(st)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadSeed(input logic [31:0] s);
    @(negedge clk);
    seedLoad = 1'b1; seedValue = s;
    @(negedge clk);
    seedLoad = 1'b0;
    // R9
    model = (s == 32'h0) ? 32'hB5AD_4ECE : s;
  endtask

  task automatic oneReq(input string req);
    @(negedge clk);
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    chk(req, {31'h0, randValid}, 32'h1);
    chk(req, randWord, pairOf(model));
    model = nxt(nxt(model));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; seedLoad = 1'b0; seedValue = '0; reqStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    chk("R1 valid", {31'h0, randValid}, 32'h0);
    chk("R1 word", randWord, 32'h0);
    model = 32'h0000_0001;
    oneReq("R1 default seed");
    oneReq("R6 second request");

    // R2 R3 R4 R5 sweep of seeds
    for (int i = 1; i <= 40; i++) begin
      loadSeed((i * 32'h9E37_79B9) ^ i);
      for (int k = 0; k < 3; k++) oneReq("R2 R3 R4 R5 seed sweep");
    end
    loadSeed(32'h0001_0000);
    oneReq("R2 low half zero");
    loadSeed(32'h0000_ABCD);
    oneReq("R2 high half zero");
    loadSeed(32'hFFFF_FFFF);
    oneReq("R3 all ones carry");

    // R3 low half equals one step, R5 high half equals the next step
    loadSeed(32'h1234_5678);
    @(negedge clk); reqStrobe = 1'b1;
    @(negedge clk); reqStrobe = 1'b0;
    chk("R3 low half", {16'h0, randWord[15:0]}, {16'h0, outOf(32'h1234_5678)});
    chk("R5 high half", {16'h0, randWord[31:16]}, {16'h0, outOf(nxt(32'h1234_5678))});
    model = nxt(nxt(32'h1234_5678));

    // R7 idle cycles change nothing
    held = randWord;
    repeat (5) @(negedge clk);
    chk("R7 idle valid", {31'h0, randValid}, 32'h0);
    chk("R7 idle word", randWord, held);
    oneReq("R7 state kept over idle");

    // R8 load and request in the same cycle
    held = randWord;
    @(negedge clk);
    seedLoad = 1'b1; reqStrobe = 1'b1; seedValue = 32'hCAFE_0101;
    @(negedge clk);
    seedLoad = 1'b0; reqStrobe = 1'b0;
    chk("R8 no valid on collision", {31'h0, randValid}, 32'h0);
    chk("R8 word held on collision", randWord, held);
    model = 32'hCAFE_0101;
    oneReq("R8 seed took effect");

    // R9 zero seed
    loadSeed(32'h0);
    oneReq("R9 zero seed substitute");

    // R6 long back-to-back run
    loadSeed(32'h0BAD_F00D);
    @(negedge clk); reqStrobe = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (k == 4999) reqStrobe = 1'b0;
      chk("R6 burst valid", {31'h0, randValid}, 32'h1);
      chk("R6 burst word", randWord, pairOf(model));
      model = nxt(nxt(model));
    end
    @(negedge clk);
    chk("R6 valid drops after burst", {31'h0, randValid}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule